// File: doc/BRIEF.md
# Set Tag Generator and Adder Pipeline Tracker

This block sits beside a pipelined adder inside a streaming accumulator that handles several vectors at once. It gives every incoming element a set tag, a small counter value that moves on by one each time the final element of a vector is accepted. The element leaves on an internal bus with its tag attached, so that later logic can tell which vector it belongs to.

The same block follows the adder itself. Whenever the control logic sends an operand pair into the adder, it raises `issue` together with the pair's tag. A chain of `PIPE_DEPTH` stages carries a valid bit and a tag in step with the adder. When an entry reaches the end of the chain, the block reports that a sum is coming out and which set it belongs to. Two equality comparators then tell the control logic what it may pair the sum with. One reports that the sum has the same tag as the element currently on the input. The other reports that another sum of the same set is still inside the adder.

The tag counter is only as wide as the largest number of sets that can be alive in the accumulator together, which is about five thirds of the adder depth. It wraps silently, and every tag comparison is an equality test on the wrapped value.

Top module: `set_tag_tracker`

## Requirements
- R1: `bus_sid` is the tag of the element on the input in the same cycle. It is held in a counter that reads 0 after reset. `bus_valid`, `bus_last` and `bus_data` repeat `in_valid`, `in_last` and `in_data` in that cycle.
- R2: The tag counter moves up by exactly one at the clock edge that ends a cycle in which `in_valid` and `in_last` are both high. In every other cycle it holds, including cycles where `in_last` is high while `in_valid` is low.
- R3: The tag is TAG_W = clog2(ceil(5*PIPE_DEPTH/3)) bits wide, with a minimum of 1, and it counts modulo 2^TAG_W. With PIPE_DEPTH = 4 this is 3 bits, so the value after 7 is 0.
- R4: If `issue` is high in cycle t, then `sum_valid` is high in cycle t+PIPE_DEPTH and `sum_sid` equals the `issue_sid` sampled in cycle t. In any cycle without such an issue, `sum_valid` is low.
- R5: `pipe_empty` is high exactly when no `issue` was accepted in the previous PIPE_DEPTH cycles. This includes the cycle in which a sum is still emerging.
- R6: `sum_match_input` is high exactly when `sum_valid` and `in_valid` are both high and `sum_sid` equals `bus_sid`.
- R7: `sum_match_inflight` is high exactly when `sum_valid` is high and a pair with the same tag was issued within the PIPE_DEPTH-1 cycles before the current one, so that it is still inside the adder.
- R8: While `rst_n` is low, the tag is 0, every stage is invalid, `pipe_empty` is high and `sum_valid` is low, with no clock edge needed. After `rst_n` rises, the state first changes at the third rising edge.
- R9: The element data passes through combinationally, whatever the tag or pipeline state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element is valid |
| in_last | input | 1 | Input element is the final one of its vector |
| in_data | input | DATA_W | Input element value |
| issue | input | 1 | An operand pair enters the adder this cycle |
| issue_sid | input | TAG_W | Tag of the operand pair that is entering |
| bus_valid | output | 1 | Tagged element valid |
| bus_last | output | 1 | Tagged element is final in its vector |
| bus_data | output | DATA_W | Tagged element value |
| bus_sid | output | TAG_W | Tag of the current element |
| sum_valid | output | 1 | Adder result emerges this cycle |
| sum_sid | output | TAG_W | Tag of the emerging result |
| sum_match_input | output | 1 | Emerging result has the same tag as the input element |
| sum_match_inflight | output | 1 | Another pair of the same set is still in the adder |
| pipe_empty | output | 1 | No entry is inside the adder pipeline |

## Verification
The bench builds the block with PIPE_DEPTH = 4 and DATA_W = 8, which makes the tag 3 bits wide. With these values, eight completed vectors are enough to show the tag wrapping. A result leaves the pipeline four cycles after its pair enters, so a short cycle table can fill the pipeline, drain it, and line up every combination of equal and unequal tags between the emerging sum, the input and the entries still in flight. Directed steps then cover the wrap, issues on every cycle, and a reset applied while the pipeline is occupied.

// File: rtl/sat_pkg.sv
package sat_pkg;

  // Largest number of sets that can be alive together, rounded up.
  function automatic int unsigned live_sets(input int unsigned depth);
    return (5 * depth + 2) / 3;
  endfunction

  // Tag width able to hold every live set at once.
  function automatic int unsigned tag_width(input int unsigned depth);
    int unsigned sets;
    sets = live_sets(depth);
    if (sets < 3) return 1;
    return $clog2(sets);
  endfunction

endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/sat_sid_counter.sv
module sat_sid_counter #(
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [TAG_W-1:0] sid
);

  localparam logic [TAG_W-1:0] INC = TAG_W'(1);

  logic [TAG_W-1:0] sid_q;
  logic [TAG_W-1:0] sid_nxt;
  logic             sid_en;

  // next state: wraps modulo 2^TAG_W by truncation
  always_comb begin
    sid_en  = step;
    sid_nxt = sid_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sid_q <= '0;
    end else if (sid_en) begin
      sid_q <= sid_nxt;
    end
  end

  assign sid = sid_q;

endmodule

// File: rtl/sat_tag_pipe.sv
module sat_tag_pipe #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned TAG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [TAG_W-1:0]       push_sid,
  output logic [DEPTH-1:0]       stage_vld,
  output logic [DEPTH*TAG_W-1:0] stage_sid
);

  logic [DEPTH-1:0]       vld_q;
  logic [DEPTH-1:0]       vld_nxt;
  logic [DEPTH*TAG_W-1:0] sid_q;
  logic [DEPTH*TAG_W-1:0] sid_nxt;
  logic [DEPTH-1:0]       sid_en;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb begin
        vld_nxt[0]             = push;
        sid_nxt[TAG_W-1:0]     = push_sid;
        sid_en[0]              = push;
      end
    end else begin : g_body
      always_comb begin
        vld_nxt[k]                 = vld_q[k-1];
        sid_nxt[k*TAG_W +: TAG_W]  = sid_q[(k-1)*TAG_W +: TAG_W];
        sid_en[k]                  = vld_q[k-1];
      end
    end

    // valid bits advance every cycle, tags load only with a live entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
      end else begin
        vld_q[k] <= vld_nxt[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sid_q[k*TAG_W +: TAG_W] <= '0;
      end else if (sid_en[k]) begin
        sid_q[k*TAG_W +: TAG_W] <= sid_nxt[k*TAG_W +: TAG_W];
      end
    end
  end

  assign stage_vld = vld_q;
  assign stage_sid = sid_q;

endmodule

// File: rtl/sat_match_unit.sv
module sat_match_unit #(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned TAG_W = 5
) (
  input  logic [DEPTH-1:0]       stage_vld,
  input  logic [DEPTH*TAG_W-1:0] stage_sid,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_sid,
  output logic                   out_valid,
  output logic [TAG_W-1:0]       out_sid,
  output logic                   hit_input,
  output logic                   hit_inflight,
  output logic                   empty
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] hit_vec;

  always_comb begin
    out_valid = stage_vld[LAST];
    out_sid   = stage_sid[LAST*TAG_W +: TAG_W];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    if (k < LAST) begin : g_live
      assign hit_vec[k] = stage_vld[k] && (stage_sid[k*TAG_W +: TAG_W] == out_sid);
    end else begin : g_tail
      assign hit_vec[k] = 1'b0;
    end
  end

  always_comb begin
    hit_input    = out_valid && in_valid && (out_sid == in_sid);
    hit_inflight = out_valid && (|hit_vec);
    empty        = ~|stage_vld;
  end

endmodule

// File: rtl/set_tag_tracker.sv
module set_tag_tracker #(
  parameter int unsigned PIPE_DEPTH = 11,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned TAG_W     = sat_pkg::tag_width(PIPE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic              issue,
  input  logic [TAG_W-1:0]  issue_sid,
  output logic              bus_valid,
  output logic              bus_last,
  output logic [DATA_W-1:0] bus_data,
  output logic [TAG_W-1:0]  bus_sid,
  output logic              sum_valid,
  output logic [TAG_W-1:0]  sum_sid,
  output logic              sum_match_input,
  output logic              sum_match_inflight,
  output logic              pipe_empty
);

  logic                        rst_int_n;
  logic [TAG_W-1:0]            cur_sid;
  logic                        set_close;
  logic [PIPE_DEPTH-1:0]       stage_vld;
  logic [PIPE_DEPTH*TAG_W-1:0] stage_sid;

  sat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign set_close = in_valid && in_last;

  sat_sid_counter #(.TAG_W(TAG_W)) u_sid (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (set_close),
    .sid   (cur_sid)
  );

  sat_tag_pipe #(.DEPTH(PIPE_DEPTH), .TAG_W(TAG_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (issue),
    .push_sid  (issue_sid),
    .stage_vld (stage_vld),
    .stage_sid (stage_sid)
  );

  sat_match_unit #(.DEPTH(PIPE_DEPTH), .TAG_W(TAG_W)) u_match (
    .stage_vld    (stage_vld),
    .stage_sid    (stage_sid),
    .in_valid     (in_valid),
    .in_sid       (cur_sid),
    .out_valid    (sum_valid),
    .out_sid      (sum_sid),
    .hit_input    (sum_match_input),
    .hit_inflight (sum_match_inflight),
    .empty        (pipe_empty)
  );

  always_comb begin
    bus_valid = in_valid;
    bus_last  = in_last;
    bus_data  = in_data;
    bus_sid   = cur_sid;
  end

endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int unsigned P     = 11,
  parameter int unsigned TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             issue,
  input logic [TAG_W-1:0] bus_sid,
  input logic             sum_valid,
  input logic             sum_match_input,
  input logic             sum_match_inflight,
  input logic             pipe_empty
);

  localparam int unsigned CNT_W = $clog2(P + 2);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  logic [CNT_W-1:0] outst_q;
  logic [CNT_W-1:0] outst_nxt;

  always_comb begin
    outst_nxt = outst_q;
    if (issue && !sum_valid) outst_nxt = outst_q + CNT_W'(1);
    if (!issue && sum_valid) outst_nxt = outst_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= outst_nxt;
  end

  // R2 R3
  sid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (bus_sid == ($past(bus_sid) + ONE)));

  // R2
  sid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> $stable(bus_sid));

  // R5
  empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_empty == (outst_q == '0));

  // R4
  sum_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (outst_q != '0));

  // R4
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= CNT_W'(P));

  // R6
  match_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_match_input |-> (sum_valid && in_valid));

  // R7
  match_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_match_inflight |-> (sum_valid && (outst_q >= CNT_W'(2))));

endmodule

bind set_tag_tracker sat_checker #(.P(PIPE_DEPTH), .TAG_W(TAG_W)) i_sat_chk (
  .clk                (clk),
  .rst_n              (rst_int_n),
  .in_valid           (in_valid),
  .in_last            (in_last),
  .issue              (issue),
  .bus_sid            (bus_sid),
  .sum_valid          (sum_valid),
  .sum_match_input    (sum_match_input),
  .sum_match_inflight (sum_match_inflight),
  .pipe_empty         (pipe_empty)
);

// File: tb/test_set_tag_tracker.sv
module test_set_tag_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int P      = 4;
  localparam int DW     = 8;
  localparam int TW     = 3;
  localparam int NROWS  = 26;

  // row: iv il is isid[2:0] | esid[2:0] esv essid[2:0] emi emf eemp
  localparam logic [15:0] VEC [NROWS] = '{
    16'b1_0_0_000_000_0_000_0_0_1,  // 0
    16'b1_0_1_000_000_0_000_0_0_1,  // 1
    16'b1_1_0_000_000_0_000_0_0_0,  // 2  closes set 0
    16'b1_0_1_000_001_0_000_0_0_0,  // 3
    16'b1_0_1_001_001_0_000_0_0_0,  // 4
    16'b1_1_0_000_001_1_000_0_1_0,  // 5  sum of row1, twin from row3 inside
    16'b0_1_0_000_010_0_000_0_0_0,  // 6  last without valid
    16'b1_0_1_001_010_1_000_0_0_0,  // 7
    16'b1_0_0_000_010_1_001_0_1_0,  // 8
    16'b1_0_1_010_010_0_000_0_0_0,  // 9
    16'b1_1_0_000_010_0_000_0_0_0,  // 10
    16'b1_0_0_000_011_1_001_0_0_0,  // 11
    16'b1_0_0_000_011_0_000_0_0_0,  // 12
    16'b1_0_0_000_011_1_010_0_0_0,  // 13
    16'b1_0_1_011_011_0_000_0_0_1,  // 14
    16'b1_0_0_000_011_0_000_0_0_0,  // 15
    16'b1_0_0_000_011_0_000_0_0_0,  // 16
    16'b1_0_0_000_011_0_000_0_0_0,  // 17
    16'b1_1_0_000_011_1_011_1_0_0,  // 18 sum tag equals input tag
    16'b0_0_0_000_100_0_000_0_0_1,  // 19
    16'b1_0_1_100_100_0_000_0_0_1,  // 20
    16'b0_0_0_000_100_0_000_0_0_0,  // 21
    16'b0_0_0_000_100_0_000_0_0_0,  // 22
    16'b0_0_0_000_100_0_000_0_0_0,  // 23
    16'b0_0_0_000_100_1_100_0_0_0,  // 24 equal tags, input not valid
    16'b0_0_0_000_100_0_000_0_0_1   // 25
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_last;
  logic [DW-1:0] in_data;
  logic          issue;
  logic [TW-1:0] issue_sid;
  logic          bus_valid;
  logic          bus_last;
  logic [DW-1:0] bus_data;
  logic [TW-1:0] bus_sid;
  logic          sum_valid;
  logic [TW-1:0] sum_sid;
  logic          sum_match_input;
  logic          sum_match_inflight;
  logic          pipe_empty;

  int n_chk;
  int n_bad;
  bit done;

  set_tag_tracker #(.PIPE_DEPTH(P), .DATA_W(DW)) i_set_tag_tracker (
    .clk                (clk),
    .rst_n              (rst_n),
    .in_valid           (in_valid),
    .in_last            (in_last),
    .in_data            (in_data),
    .issue              (issue),
    .issue_sid          (issue_sid),
    .bus_valid          (bus_valid),
    .bus_last           (bus_last),
    .bus_data           (bus_data),
    .bus_sid            (bus_sid),
    .sum_valid          (sum_valid),
    .sum_sid            (sum_sid),
    .sum_match_input    (sum_match_input),
    .sum_match_inflight (sum_match_inflight),
    .pipe_empty         (pipe_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic il, input logic is, input logic [TW-1:0] isid);
    in_valid  = iv;
    in_last   = il;
    issue     = is;
    issue_sid = isid;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    in_data = '0;
    drive(1'b0, 1'b0, 1'b0, '0);

    // R8 reset state
    #(CLK_PERIOD * 3 + 1);
    check("R8", "pipe_empty in reset", int'(pipe_empty), 1);
    check("R8", "sum_valid in reset", int'(sum_valid), 0);
    check("R1", "bus_sid in reset", int'(bus_sid), 0);

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);

    // table walk: R1 R2 R4 R5 R6 R7 R9
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:10]);
      in_data = DW'(i * 7 + 3);
      #1;
      check("R1", "bus_sid", int'(bus_sid), int'(VEC[i][9:7]));
      check("R4", "sum_valid", int'(sum_valid), int'(VEC[i][6]));
      if (VEC[i][6]) check("R4", "sum_sid", int'(sum_sid), int'(VEC[i][5:3]));
      check("R6", "sum_match_input", int'(sum_match_input), int'(VEC[i][2]));
      check("R7", "sum_match_inflight", int'(sum_match_inflight), int'(VEC[i][1]));
      check("R5", "pipe_empty", int'(pipe_empty), int'(VEC[i][0]));
      check("R9", "bus_data", int'(bus_data), i * 7 + 3);
      check("R9", "bus_valid", int'(bus_valid), int'(VEC[i][15]));
      check("R9", "bus_last", int'(bus_last), int'(VEC[i][14]));
    end

    // R3 wrap: tag is 4, four closes bring it to 0, one more to 1
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b0, '0);
      #1;
      check("R3", "bus_sid during wrap", int'(bus_sid), (4 + j) % 8);
    end
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0);
    #1;
    check("R3", "bus_sid after wrap", int'(bus_sid), 1);

    // R4 R7 issue on every cycle with distinct tags
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      drive(1'b0, 1'b0, (j < 6), TW'(j));
      #1;
      check("R4", "back-to-back sum_valid", int'(sum_valid), (j >= 4) ? 1 : 0);
      if (j >= 4) check("R4", "back-to-back sum_sid", int'(sum_sid), j - 4);
      check("R7", "distinct tags inflight", int'(sum_match_inflight), 0);
      check("R5", "back-to-back pipe_empty", int'(pipe_empty), (j == 0) ? 1 : 0);
    end

    // R8 asynchronous reset with entries still inside
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    #1;
    check("R8", "pipe_empty on async reset", int'(pipe_empty), 1);
    check("R8", "sum_valid on async reset", int'(sum_valid), 0);
    check("R8", "bus_sid on async reset", int'(bus_sid), 0);

    // R8 release: two edges of sync, then third edge captures
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 3'd5);
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R8", "tag held during release", int'(bus_sid), 0);
    check("R8", "pipe held during release", int'(pipe_empty), 1);
    @(posedge clk);
    #1;
    check("R8", "tag after first live edge", int'(bus_sid), 1);
    check("R8", "pipe after first live edge", int'(pipe_empty), 0);

    done = 1'b1;
    summary();
  end

endmodule